// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital control logic for a 5-bit RF step attenuator with 1 dB steps. It turns one of three kinds of programming into a single registered 5-bit attenuation state, which drives the switched attenuator array. The three kinds are a clocked serial word, a parallel word latched by a strobe, and parallel pins that act directly. A mode input chooses between serial and parallel control. In parallel mode, the strobe level tells latched operation apart from direct operation.

All control inputs are asynchronous to the system clock. A parameterised synchronizer chain samples them, and edge detection on the sampled serial clock replaces a separate clock domain. Behind the serial shift register, and also on the parallel pins, a single latch stage passes its source while the strobe is high and holds it while the strobe is low. After reset the state sits at maximum attenuation. It stays there for a power-up hold whose length in cycles comes from the clock frequency and a delay in microseconds. Once the hold ends, a valid flag rises. From then on the state follows the latch rules.

Top module: `atten_ctrl`

## Requirements
- R1: While reset is asserted, `att_state` is 31 (all ones) and `state_valid` is 0.
- R2: For HOLD_CYCLES cycles after reset is released, `att_state` stays at 31 and `state_valid` stays 0, whatever the strobe, pins and serial inputs do.
- R3: In parallel mode (`ser_mode`=0) with the strobe high after the hold, `att_state` follows `par_ctl`. Bit 4 is worth 16 dB, bit 3 is 8 dB, bit 2 is 4 dB, bit 1 is 2 dB and bit 0 is 1 dB.
- R4: In parallel mode with the strobe low, changes on `par_ctl` have no effect. A high-then-low strobe pulse leaves the pin value present at the falling edge.
- R5: The serial shift register is 8 bits wide and shifts on each rising edge of `ser_clk`. The first bit received ends up in bit 0. Word bits 6..2 give the attenuation (bit 6 = 16 dB, down to bit 2 = 1 dB), so the word is the dB value times 4. Bits 7, 1 and 0 are ignored.
- R6: In serial mode, shifting with the strobe low does not change `att_state`. Raising the strobe transfers word bits 6..2 to the state.
- R7: In serial mode `par_ctl` has no effect on the state. In parallel mode the serial word has no effect on the state.
- R8: If the strobe is low when reset is released, `att_state` stays at 31 after the hold until a strobe pulse latches a new value.
- R9: In direct operation, all pins low (undriven) gives 0 dB.
- R10: Once `state_valid` rises, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ser_mode | input | 1 | 1 selects serial control, 0 selects parallel pins |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial data, sent LSB first |
| ser_le | input | 1 | Latch strobe: the latch is transparent while high |
| par_ctl | input | 5 | Parallel attenuation pins, bit 4 = 16 dB down to bit 0 = 1 dB |
| att_state | output | 5 | Registered attenuation state in dB |
| state_valid | output | 1 | High once the power-up hold has ended |

## Verification
The bench builds the block with CLK_HZ = 100 MHz and HOLD_US = 1. This shortens the hold from 40000 cycles to 100, so the end of the hold, and both power-up paths (strobe high and strobe low), fall within a short run. SYNC_STAGES stays at its default of 2. The bench drives the serial clock and strobe many system cycles per phase, so that every edge passes through the synchronizers. It then checks the state only after the pipeline has settled.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATT_BITS  = 5;
  localparam int WORD_BITS = 8;
  localparam int WORD_LSB  = 2;

  typedef logic [ATT_BITS-1:0] att_t;

  localparam att_t ATT_MAX = '1;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/atten_shift.sv
module atten_shift
  import atten_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_s,
  input  logic                 sdi_s,
  output logic [WORD_BITS-1:0] word
);
  logic sclk_d;
  logic rise;

  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      word   <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (rise) word <= {sdi_s, word[WORD_BITS-1:1]};
    end
  end

  AST_NO_SHIFT_LOW: assert property (@(posedge clk) disable iff (rst)
    !sclk_s |=> $stable(word)); // R5
  AST_SHIFT_ENTERS_TOP: assert property (@(posedge clk) disable iff (rst)
    (sclk_s && !sclk_d) |=> word[WORD_BITS-1] == $past(sdi_s)); // R5
endmodule

// File: rtl/atten_hold.sv
module atten_hold #(
  parameter int HOLD_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R10
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int HOLD_US     = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_mode,
  input  logic                ser_clk,
  input  logic                ser_data,
  input  logic                ser_le,
  input  logic [ATT_BITS-1:0] par_ctl,
  output logic [ATT_BITS-1:0] att_state,
  output logic                state_valid
);
  localparam int HOLD_CYCLES = (CLK_HZ / 1_000_000) * HOLD_US;
  localparam int SW          = 4 + ATT_BITS;

  logic [SW-1:0]        raw_in, syn_in;
  logic                 mode_s, sclk_s, sdi_s, le_s;
  att_t                 pins_s;
  logic [WORD_BITS-1:0] word;
  logic                 hold_done;
  att_t                 src;

  assign raw_in = {ser_mode, ser_clk, ser_data, ser_le, par_ctl};

  atten_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign {mode_s, sclk_s, sdi_s, le_s, pins_s} = syn_in;

  atten_shift u_shift (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sclk_s),
    .sdi_s  (sdi_s),
    .word   (word)
  );

  atten_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .done (hold_done)
  );

  assign src = mode_s ? word[WORD_LSB +: ATT_BITS] : pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      att_state   <= ATT_MAX;
      state_valid <= 1'b0;
    end else begin
      state_valid <= hold_done;
      if (hold_done && le_s) att_state <= src;
    end
  end

  AST_HOLD_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    !state_valid |-> att_state == ATT_MAX); // R2
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    state_valid |=> state_valid); // R10
  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !le_s |=> $stable(att_state)); // R4
  AST_SERIAL_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    (state_valid && le_s && mode_s) |=> att_state == $past(word[WORD_LSB +: ATT_BITS])); // R6
  AST_PARALLEL_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    (state_valid && le_s && !mode_s) |=> att_state == $past(pins_s)); // R3
endmodule

// File: tb/tb_atten_ctrl.sv
module tb_atten_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_mode = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_le = 1'b1;
  logic [4:0] par_ctl = 5'd5;
  logic [4:0] att_state;
  logic       state_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  atten_ctrl #(.CLK_HZ(100_000_000), .HOLD_US(1), .SYNC_STAGES(2)) dut (
    .clk         (clk),
    .rst         (rst),
    .ser_mode    (ser_mode),
    .ser_clk     (ser_clk),
    .ser_data    (ser_data),
    .ser_le      (ser_le),
    .par_ctl     (par_ctl),
    .att_state   (att_state),
    .state_valid (state_valid)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      ser_data = w[i];
      ser_clk  = 1'b0;
      step(4);
      ser_clk  = 1'b1;
      step(4);
    end
    ser_clk = 1'b0;
    step(6);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    step(6);
    ser_le = 1'b0;
    step(8);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 300 && !state_valid; i++) step(1);
    step(8);
  endtask

  task automatic t_reset_and_hold();
    step(4);
    chk("R1 state in reset", att_state, 31);
    chk("R1 valid in reset", state_valid, 0);
    rst = 1'b0;
    step(30);
    par_ctl = 5'd9;
    ser_le = 1'b0;
    step(10);
    ser_le = 1'b1;
    step(10);
    chk("R2 state during hold", att_state, 31);
    chk("R2 valid during hold", state_valid, 0);
    par_ctl = 5'd5;
    wait_valid();
    chk("R2 valid after hold", state_valid, 1);
    chk("R3 direct after hold", att_state, 5);
  endtask

  task automatic t_direct();
    par_ctl = 5'd0;  step(8);
    chk("R9 pins low give 0 dB", att_state, 0);
    par_ctl = 5'd31; step(8);
    chk("R3 all pins high", att_state, 31);
    par_ctl = 5'd17; step(8);
    chk("R3 16+1 dB", att_state, 17);
  endtask

  task automatic t_latched();
    ser_le = 1'b0;  step(8);
    par_ctl = 5'd9; step(10);
    chk("R4 pins ignored while closed", att_state, 17);
    pulse_le();
    chk("R4 pulse captures pins", att_state, 9);
    par_ctl = 5'd3; step(10);
    chk("R4 held after pulse", att_state, 9);
  endtask

  task automatic t_serial();
    ser_mode = 1'b1; step(6);
    shift_word(8'hB4);
    chk("R6 shift with strobe low", att_state, 9);
    pulse_le();
    chk("R5 word 13 dB with bit 7 set", att_state, 13);
    shift_word(8'h83);
    pulse_le();
    chk("R5 bits 7,1,0 ignored", att_state, 0);
    shift_word(8'h7F);
    pulse_le();
    chk("R5 31 dB word", att_state, 31);
    shift_word(8'h28);
    pulse_le();
    chk("R5 10 dB word", att_state, 10);
  endtask

  task automatic t_mode_select();
    ser_le = 1'b1;
    par_ctl = 5'd22; step(10);
    chk("R7 pins ignored in serial mode", att_state, 10);
    ser_mode = 1'b0; step(8);
    chk("R7 parallel mode takes pins", att_state, 22);
    shift_word(8'h1C);
    chk("R7 serial word ignored in parallel", att_state, 22);
    chk("R10 valid still high", state_valid, 1);
    ser_le = 1'b0; step(4);
  endtask

  task automatic t_latched_powerup();
    rst = 1'b1;
    ser_le = 1'b0;
    par_ctl = 5'd6;
    step(4);
    chk("R1 state in second reset", att_state, 31);
    rst = 1'b0;
    wait_valid();
    step(20);
    chk("R8 valid after hold", state_valid, 1);
    chk("R8 stays at max until latched", att_state, 31);
    pulse_le();
    chk("R8 latch after power-up", att_state, 6);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100_000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100_000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset_and_hold();
    t_direct();
    t_latched();
    t_serial();
    t_mode_select();
    t_latched_powerup();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule